// File: doc/BRIEF.md
# Dual-Channel Converter Data Path Controller

This block is the digital front end of a two-channel 12-bit digital-to-analog converter. It sits on a simple write/read register bus. For each channel it keeps a holding register and an output code register. Software loads a holding register through one of three alignment views. A packed view loads both channels in one write. Each channel has its own enable and trigger controls, which decide when the holding value moves to the output code. The move happens either on the cycle after the write, or one clock after a selected trigger is sampled. The trigger can be a hardware line or a software bit.

Each channel runs a small state machine with four states. `CH_OFF` is the channel disabled. `CH_FOLLOW` is enabled with no trigger: the output tracks the holding register. `CH_WAIT` is enabled with a trigger: the channel is armed and idle. `CH_LOAD` means a trigger was sampled, and the output takes the holding value on this cycle's edge. The transitions are:
- OFF→FOLLOW or OFF→WAIT when the channel is enabled, depending on the trigger enable.
- FOLLOW↔WAIT when the trigger enable is toggled.
- WAIT→LOAD on a sampled trigger.
- LOAD→LOAD on a back-to-back trigger, and LOAD→WAIT otherwise.
- Any state→OFF when the channel is disabled.

A hardware trigger accepted while DMA is enabled raises a DMA request, which stays up until it is acknowledged. A hardware trigger that arrives while a request is still unacknowledged sets a sticky underrun flag. The flag can raise an interrupt. The two 12-bit output codes drive the converter.

Top module: `dacf_core`

## Requirements
- R1: After reset both output codes, both DMA requests, the interrupt, the control word, the software trigger bits and the status word are all zero.
- R2: Channel 0 holding writes use offsets 0x08, 0x0C and 0x10; channel 1 uses 0x14, 0x18 and 0x1C. The three offsets of each channel take, in order:
  - bits 11:0 (12-bit right-aligned);
  - bits 15:4 (12-bit left-aligned);
  - bits 7:0 placed at code bits 11:4 with bits 3:0 zero (8-bit).
- R3: The packed write at 0x20 loads channel 0 from bits 11:0 and channel 1 from bits 27:16. At 0x24 it loads channel 0 from bits 15:4 and channel 1 from bits 31:20. At 0x28 it loads channel 0 from bits 7:0 and channel 1 from bits 15:8, both in 8-bit form.
- R4: The control word at 0x00 holds the channel 0 field in bits 15:0 and the channel 1 field, with the same layout, in bits 31:16. In each field:
  - bit 0 is enable;
  - bit 1 is trigger enable;
  - bits 4:2 are the trigger source (0..NUM_HW-1 a hardware line, 7 software);
  - bit 5 is DMA enable;
  - bit 6 is underrun interrupt enable.
  With the channel enabled and the trigger disabled, the output code equals the holding value one clock after the holding write.
- R5: While a channel is disabled its output code does not change, but holding writes still land. The holding value reads back in 12-bit right-aligned form at 0x08 (channel 0) or 0x14 (channel 1).
- R6: With a hardware trigger source selected, the output code takes the holding value one clock after the selected line is sampled high. Lines that are not selected have no effect.
- R7: Writing 1 to bit 0 or bit 1 of 0x04 sets the software trigger for channel 0 or 1, and both may be set in one write. A channel armed for the software source moves its holding value to its output two clocks after that write's edge. Its trigger bit reads 0 once the output has changed.
- R8: A hardware trigger accepted with DMA enabled raises that channel's DMA request, which holds until the acknowledge input. A software trigger never raises it.
- R9: A hardware trigger accepted while the DMA request is high and not acknowledged in the same cycle sets the underrun flag. The flag is bit 0 (channel 0) or bit 16 (channel 1) of 0x34 and is cleared by writing 1 to that bit. The interrupt output is high when any flag is set with its interrupt enable.
- R10: A control write leaves a channel's trigger source unchanged while that channel is enabled. The other fields still update.
- R11: The output codes read back at 0x2C (channel 0) and 0x30 (channel 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_trig | input | NUM_HW | Hardware trigger lines |
| dma_ack | input | 2 | DMA acknowledge per channel |
| dma_req | output | 2 | DMA request per channel |
| irq | output | 1 | Underrun interrupt |
| dac_code0 | output | 12 | Channel 0 output code |
| dac_code1 | output | 12 | Channel 1 output code |

## Verification
The holding-to-output path is driven with random data through all three single-channel views and all three packed views, with both channels in follow mode. A swapped bit field or a wrong lane shows up as a mismatch on the code of the affected channel only. Triggered mode is tried three ways:
- pulses on a non-selected line, which show that line selection is decoded;
- pulses on the selected line, which show the one-clock transfer delay;
- the software bit, which shows the self-clearing behaviour and the absence of any DMA request.

Pairs of hardware triggers with and without an acknowledge in between separate a pending request from an underrun. The per-channel interrupt enables show which flag drives the interrupt.

// File: rtl/dacf_pkg.sv
package dacf_pkg;

    localparam int CODE_W = 12;
    localparam int TSEL_W = 3;
    localparam int FIELD_W = 16;
    localparam logic [TSEL_W-1:0] SEL_SOFT = 3'd7;

    // Per-channel control field, bit 0 = enable
    typedef struct packed {
        logic              udr_ie;
        logic              dma_en;
        logic [TSEL_W-1:0] sel;
        logic              trig_en;
        logic              en;
    } ch_ctrl_t;

    localparam int CTRL_BITS = $bits(ch_ctrl_t);

    typedef enum logic [1:0] {
        CH_OFF,
        CH_FOLLOW,
        CH_WAIT,
        CH_LOAD
    } ch_state_e;

    typedef enum logic [1:0] {
        FMT_R12 = 2'd0,
        FMT_L12 = 2'd1,
        FMT_R8  = 2'd2
    } fmt_e;

    localparam logic [5:0] OFS_CTRL  = 6'h00;
    localparam logic [5:0] OFS_SOFT  = 6'h04;
    localparam logic [5:0] OFS_HOLD0 = 6'h08;
    localparam logic [5:0] OFS_HOLD1 = 6'h14;
    localparam logic [5:0] OFS_PAIR  = 6'h20;
    localparam logic [5:0] OFS_OUT0  = 6'h2C;
    localparam logic [5:0] OFS_OUT1  = 6'h30;
    localparam logic [5:0] OFS_STAT  = 6'h34;

    function automatic logic [CODE_W-1:0] place_code(input fmt_e fmt, input logic [15:0] lane);
        unique case (fmt)
            FMT_R12: place_code = lane[11:0];
            FMT_L12: place_code = lane[15:4];
            default: place_code = {lane[7:0], 4'h0};
        endcase
    endfunction

endpackage

// File: rtl/dacf_bus_decode.sv
module dacf_bus_decode
    import dacf_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                  wr_en,
    input  logic [5:0]            addr,
    input  logic [31:0]           wdata,
    output logic                  ctrl_we,
    output logic [NUM_CH-1:0]     hold_we,
    output logic [CODE_W-1:0]     hold_val [NUM_CH],
    output logic [NUM_CH-1:0]     soft_set,
    output logic [NUM_CH-1:0]     udr_clr
);

    assign ctrl_we = wr_en && (addr == OFS_CTRL);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        localparam logic [5:0] SBASE = OFS_HOLD0 + 6'(c * 12);

        assign soft_set[c] = wr_en && (addr == OFS_SOFT) && wdata[c];
        assign udr_clr[c]  = wr_en && (addr == OFS_STAT) && wdata[FIELD_W*c];

        always_comb begin
            hold_we[c]  = 1'b0;
            hold_val[c] = '0;
            if (wr_en) begin
                if (addr == SBASE) begin
                    hold_we[c]  = 1'b1;
                    hold_val[c] = place_code(FMT_R12, wdata[15:0]);
                end else if (addr == SBASE + 6'd4) begin
                    hold_we[c]  = 1'b1;
                    hold_val[c] = place_code(FMT_L12, wdata[15:0]);
                end else if (addr == SBASE + 6'd8) begin
                    hold_we[c]  = 1'b1;
                    hold_val[c] = place_code(FMT_R8, wdata[15:0]);
                end else if (addr == OFS_PAIR) begin
                    hold_we[c]  = 1'b1;
                    hold_val[c] = place_code(FMT_R12, wdata[16*c +: 16]);
                end else if (addr == OFS_PAIR + 6'd4) begin
                    hold_we[c]  = 1'b1;
                    hold_val[c] = place_code(FMT_L12, wdata[16*c +: 16]);
                end else if (addr == OFS_PAIR + 6'd8) begin
                    hold_we[c]  = 1'b1;
                    hold_val[c] = place_code(FMT_R8, {8'h00, wdata[8*c +: 8]});
                end
            end
        end
    end

endmodule

// File: rtl/dacf_channel.sv
module dacf_channel
    import dacf_pkg::*;
#(
    parameter int NUM_HW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  ch_ctrl_t          ctrl_wdata,
    input  logic              hold_we,
    input  logic [CODE_W-1:0] hold_val,
    input  logic              soft_set,
    input  logic              udr_clr,
    input  logic [NUM_HW-1:0] hw_trig,
    input  logic              dma_ack,
    output ch_ctrl_t          ctrl_q,
    output logic [CODE_W-1:0] hold_q,
    output logic [CODE_W-1:0] code_q,
    output logic              soft_pend,
    output logic              dma_req,
    output logic              udr,
    output logic              irq,
    output logic              armed
);

    localparam int PAD_W = 1 << TSEL_W;

    ch_state_e        state_q, state_d;
    logic [PAD_W-1:0] hw_pad;
    logic             is_soft, trig_evt, hw_hit, soft_take, copy_now;

    always_comb begin
        hw_pad = '0;
        hw_pad[NUM_HW-1:0] = hw_trig;
    end

    assign is_soft   = (ctrl_q.sel == SEL_SOFT);
    assign trig_evt  = is_soft ? soft_pend : hw_pad[ctrl_q.sel];
    assign armed     = (state_q == CH_WAIT) || (state_q == CH_LOAD);
    assign hw_hit    = armed && ctrl_q.en && ctrl_q.trig_en && !is_soft && trig_evt;
    assign soft_take = armed && ctrl_q.en && ctrl_q.trig_en && is_soft && soft_pend;
    assign copy_now  = ctrl_q.en && ((state_q == CH_FOLLOW) || (state_q == CH_LOAD));
    assign irq       = udr && ctrl_q.udr_ie;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: begin
                if (ctrl_q.en) state_d = ctrl_q.trig_en ? CH_WAIT : CH_FOLLOW;
            end
            CH_FOLLOW: begin
                if (!ctrl_q.en)          state_d = CH_OFF;
                else if (ctrl_q.trig_en) state_d = CH_WAIT;
            end
            CH_WAIT, CH_LOAD: begin
                if (!ctrl_q.en)           state_d = CH_OFF;
                else if (!ctrl_q.trig_en) state_d = CH_FOLLOW;
                else if (trig_evt)        state_d = CH_LOAD;
                else                      state_d = CH_WAIT;
            end
        endcase
    end

    // Registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            hold_q    <= '0;
            code_q    <= '0;
            soft_pend <= 1'b0;
            dma_req   <= 1'b0;
            udr       <= 1'b0;
        end else begin
            if (ctrl_we) begin
                ctrl_q.en      <= ctrl_wdata.en;
                ctrl_q.trig_en <= ctrl_wdata.trig_en;
                ctrl_q.dma_en  <= ctrl_wdata.dma_en;
                ctrl_q.udr_ie  <= ctrl_wdata.udr_ie;
                if (!ctrl_q.en) ctrl_q.sel <= ctrl_wdata.sel;
            end
            if (hold_we)  hold_q <= hold_val;
            if (copy_now) code_q <= hold_q;

            if (soft_set)       soft_pend <= 1'b1;
            else if (soft_take) soft_pend <= 1'b0;

            if (hw_hit && ctrl_q.dma_en) dma_req <= 1'b1;
            else if (dma_ack)            dma_req <= 1'b0;

            if (hw_hit && ctrl_q.dma_en && dma_req && !dma_ack) udr <= 1'b1;
            else if (udr_clr)                                   udr <= 1'b0;
        end
    end

endmodule

// File: rtl/dacf_core.sv
module dacf_core
    import dacf_pkg::*;
#(
    parameter int NUM_HW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [5:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_HW-1:0] hw_trig,
    input  logic [1:0]        dma_ack,
    output logic [1:0]        dma_req,
    output logic              irq,
    output logic [CODE_W-1:0] dac_code0,
    output logic [CODE_W-1:0] dac_code1
);

    localparam int NUM_CH = 2;

    logic                ctrl_we;
    logic [NUM_CH-1:0]   hold_we, soft_set, udr_clr, soft_pend, udr, ch_irq, armed, ch_en, soft_mode;
    logic [CODE_W-1:0]   hold_val [NUM_CH];
    logic [CODE_W-1:0]   hold_q   [NUM_CH];
    logic [CODE_W-1:0]   code_q   [NUM_CH];
    ch_ctrl_t            ctrl_q   [NUM_CH];
    logic [TSEL_W*NUM_CH-1:0] sel_flat;

    dacf_bus_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ctrl_we  (ctrl_we),
        .hold_we  (hold_we),
        .hold_val (hold_val),
        .soft_set (soft_set),
        .udr_clr  (udr_clr)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dacf_channel #(.NUM_HW(NUM_HW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_we    (ctrl_we),
            .ctrl_wdata (ch_ctrl_t'(bus_wdata[FIELD_W*c +: CTRL_BITS])),
            .hold_we    (hold_we[c]),
            .hold_val   (hold_val[c]),
            .soft_set   (soft_set[c]),
            .udr_clr    (udr_clr[c]),
            .hw_trig    (hw_trig),
            .dma_ack    (dma_ack[c]),
            .ctrl_q     (ctrl_q[c]),
            .hold_q     (hold_q[c]),
            .code_q     (code_q[c]),
            .soft_pend  (soft_pend[c]),
            .dma_req    (dma_req[c]),
            .udr        (udr[c]),
            .irq        (ch_irq[c]),
            .armed      (armed[c])
        );
        assign ch_en[c]     = ctrl_q[c].en;
        assign soft_mode[c] = ctrl_q[c].trig_en && (ctrl_q[c].sel == SEL_SOFT);
        assign sel_flat[TSEL_W*c +: TSEL_W] = ctrl_q[c].sel;
    end

    assign irq       = |ch_irq;
    assign dac_code0 = code_q[0];
    assign dac_code1 = code_q[1];

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL:  bus_rdata = {{(FIELD_W-CTRL_BITS){1'b0}}, ctrl_q[1],
                                    {(FIELD_W-CTRL_BITS){1'b0}}, ctrl_q[0]};
            OFS_SOFT:  bus_rdata = {30'd0, soft_pend};
            OFS_HOLD0: bus_rdata = {20'd0, hold_q[0]};
            OFS_HOLD1: bus_rdata = {20'd0, hold_q[1]};
            OFS_OUT0:  bus_rdata = {20'd0, code_q[0]};
            OFS_OUT1:  bus_rdata = {20'd0, code_q[1]};
            OFS_STAT:  bus_rdata = {15'd0, udr[1], 15'd0, udr[0]};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dacf_checks.sv
module dacf_checks
    import dacf_pkg::*;
#(
    parameter int NUM_HW = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctrl_we,
    input logic [1:0]            ch_en,
    input logic [1:0]            armed,
    input logic [1:0]            soft_mode,
    input logic [1:0]            soft_set,
    input logic [1:0]            soft_pend,
    input logic [TSEL_W*2-1:0]   sel_flat,
    input logic [CODE_W-1:0]     dac_code0,
    input logic [CODE_W-1:0]     dac_code1,
    input logic [1:0]            dma_req,
    input logic [1:0]            udr,
    input logic [NUM_HW-1:0]     hw_trig
);

    logic [CODE_W*2-1:0] codes;
    assign codes = {dac_code1, dac_code0};

    for (genvar c = 0; c < 2; c++) begin : g_chk
        // R5: a disabled channel keeps its output code
        a_r5_off_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[c] |=> $stable(codes[CODE_W*c +: CODE_W]));

        // R10: source select frozen while enabled
        a_r10_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[c] && ctrl_we) |=> (sel_flat[TSEL_W*c +: TSEL_W] == $past(sel_flat[TSEL_W*c +: TSEL_W])));

        // R7: an armed software trigger bit is consumed in one cycle
        a_r7_soft_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (soft_pend[c] && ch_en[c] && armed[c] && soft_mode[c] && !soft_set[c]) |=> !soft_pend[c]);

        // R8: a DMA request only follows a hardware line
        a_r8_req_from_hw: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dma_req[c]) |-> $past(|hw_trig));

        // R9: underrun only with a request outstanding
        a_r9_udr_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(udr[c]) |-> $past(dma_req[c]));
    end

endmodule

bind dacf_core dacf_checks #(.NUM_HW(NUM_HW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_we   (ctrl_we),
    .ch_en     (ch_en),
    .armed     (armed),
    .soft_mode (soft_mode),
    .soft_set  (soft_set),
    .soft_pend (soft_pend),
    .sel_flat  (sel_flat),
    .dac_code0 (dac_code0),
    .dac_code1 (dac_code1),
    .dma_req   (dma_req),
    .udr       (udr),
    .hw_trig   (hw_trig)
);

// File: tb/dacf_core_bench.sv
module dacf_core_bench;

    localparam int NUM_HW = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [5:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_HW-1:0] hw_trig = '0;
    logic [1:0]        dma_ack = '0;
    logic [1:0]        dma_req;
    logic              irq;
    logic [11:0]       dac_code0, dac_code1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [11:0] exp_code [2];
    logic [31:0] rv;

    always #5 clk = ~clk;

    dacf_core #(.NUM_HW(NUM_HW)) u_dacf_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
        .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq),
        .dac_code0(dac_code0), .dac_code1(dac_code1)
    );

    function automatic logic [11:0] f_align(input int fmt, input logic [15:0] lane);
        if (fmt == 0)      return lane[11:0];
        else if (fmt == 1) return lane[15:4];
        else               return {lane[7:0], 4'h0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NUM_HW-1:0] m);
        hw_trig = m;
        @(negedge clk);
        hw_trig = '0;
    endtask

    task automatic check_codes(input string tag);
        chk(tag, {20'd0, dac_code0}, {20'd0, exp_code[0]});
        chk(tag, {20'd0, dac_code1}, {20'd0, exp_code[1]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        exp_code[0] = '0; exp_code[1] = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check_codes("R1 reset codes");
        chk("R1 reset dma", {30'd0, dma_req}, 32'd0);
        chk("R1 reset irq", {31'd0, irq}, 32'd0);
        rd(6'h00, rv); chk("R1 reset ctrl", rv, 32'd0);
        rd(6'h34, rv); chk("R1 reset status", rv, 32'd0);

        // R5 disabled channel: holding updates, output does not
        wr(6'h08, 32'h0000_0ABC);
        tick(2);
        check_codes("R5 disabled output");
        rd(6'h08, rv); chk("R5 holding readback", rv, 32'h0000_0ABC);

        // R4 follow mode on both channels
        wr(6'h00, 32'h0001_0001);
        tick(2);
        exp_code[0] = 12'hABC;
        check_codes("R4 follow after enable");

        // R2 R3 random writes through all views
        for (int i = 0; i < 30; i++) begin
            int kind;
            int fmt;
            logic [31:0] d;
            kind = int'($urandom % 3);
            fmt  = int'($urandom % 3);
            d    = $urandom;
            if (kind < 2) begin
                wr(6'(8 + 12 * kind + 4 * fmt), d);
                exp_code[kind] = f_align(fmt, d[15:0]);
            end else begin
                wr(6'(32 + 4 * fmt), d);
                for (int c = 0; c < 2; c++)
                    exp_code[c] = f_align(fmt, (fmt == 2) ? {8'h00, d[8*c +: 8]} : d[16*c +: 16]);
            end
            tick(1);
            check_codes("R2 R3 format write");
        end
        // directed packed 8-bit corner
        wr(6'h28, 32'hFFFF_A5FF);
        exp_code[0] = 12'hFF0; exp_code[1] = 12'hA50;
        tick(1);
        check_codes("R3 packed 8-bit");
        rd(6'h2C, rv); chk("R11 out0 readback", rv, 32'h0000_0FF0);
        rd(6'h30, rv); chk("R11 out1 readback", rv, 32'h0000_0A50);

        // R6 hardware triggers: ch0 line 2, ch1 line 4
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h0013_000B);
        tick(1);
        wr(6'h08, 32'h0000_0123);
        wr(6'h14, 32'h0000_0456);
        tick(2);
        check_codes("R6 no trigger yet");
        pulse(6'b001000);
        tick(1);
        check_codes("R6 unselected line");
        pulse(6'b000100);
        tick(1);
        exp_code[0] = 12'h123;
        check_codes("R6 line 2 transfer");
        pulse(6'b010000);
        tick(1);
        exp_code[1] = 12'h456;
        check_codes("R6 line 4 transfer");
        for (int i = 0; i < 8; i++) begin
            logic [31:0] d;
            d = $urandom;
            wr(6'h08, d);
            pulse(6'b000100);
            tick(1);
            exp_code[0] = d[11:0];
            check_codes("R6 random trigger");
        end

        // R10 source locked while enabled
        wr(6'h00, 32'h0013_0017);
        rd(6'h00, rv); chk("R10 sel locked", rv, 32'h0013_000B);

        // R7 software triggers, DMA enabled but never requested (R8)
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h003F_003F);
        tick(1);
        wr(6'h20, 32'h0654_0321);
        tick(2);
        check_codes("R7 waiting for soft bit");
        wr(6'h04, 32'h3);
        tick(2);
        exp_code[0] = 12'h321; exp_code[1] = 12'h654;
        check_codes("R7 soft transfer");
        rd(6'h04, rv); chk("R7 soft bits cleared", rv, 32'h0);
        chk("R8 no dma on soft", {30'd0, dma_req}, 32'd0);

        // R8 DMA on hardware triggers; R9 underrun
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h0033_006B);
        tick(1);
        pulse(6'b000100);
        chk("R8 req raised", {30'd0, dma_req}, 32'd1);
        tick(3);
        chk("R8 req held", {30'd0, dma_req}, 32'd1);
        dma_ack = 2'b01;
        @(negedge clk);
        dma_ack = 2'b00;
        chk("R8 req acked", {30'd0, dma_req}, 32'd0);
        rd(6'h34, rv); chk("R9 no underrun after ack", rv, 32'h0);
        pulse(6'b000100);
        pulse(6'b000100);
        rd(6'h34, rv); chk("R9 underrun ch0", rv, 32'h0000_0001);
        chk("R9 irq ch0", {31'd0, irq}, 32'd1);
        pulse(6'b010000);
        pulse(6'b010000);
        rd(6'h34, rv); chk("R9 underrun both", rv, 32'h0001_0001);
        wr(6'h34, 32'h0000_0001);
        rd(6'h34, rv); chk("R9 clear ch0", rv, 32'h0001_0000);
        chk("R9 irq masked ch1", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule